// File: doc/BRIEF.md
# Power Mode Controller

This block holds the power mode of a battery-powered power-management device. The three modes are Off, Standby and Active. Its inputs are already-synchronized digital flags: three wake sources (push button, wall adapter, USB attach), a power-down request, and three battery flags (battery present, battery above the undervoltage lockout threshold, battery above the low-alarm threshold). Its outputs are the current mode and two single-cycle event strobes, one for power-on and one for power-off. A separate rail sequencer uses these strobes.

Each wake source and the power-down request pass through a stability filter before the mode logic sees them. An input must be held high for `FILT_LEN` consecutive clock samples to qualify. A qualified input produces one event. The input must drop and be held again before it can produce another. The battery flags go straight to the mode logic.

When a battery is good and above the low-alarm level, Off moves straight to Active on a qualified wake, and Standby is skipped. When a battery is good but below the low-alarm level, Off moves to Standby at once. A later qualified wake then moves Standby to Active.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the mode is Off and both event strobes are low.
- R2: A wake source or power-down request is acted on only after it has been sampled high on `FILT_LEN` consecutive clock edges. A shorter pulse has no effect. With a single register stage after qualification, the mode changes on the edge after the `FILT_LEN`-th high sample.
- R3: In Off, with the battery good (present and above lockout) but below the low-alarm level, the mode becomes Standby on the next edge. No event strobe fires.
- R4: In Off, with the battery good and above the low-alarm level, a qualified wake moves the mode directly to Active. Without a wake, the mode stays Off.
- R5: In Standby, a qualified wake from any one of the button, the wall adapter or USB moves the mode to Active.
- R6: In Standby, losing a good battery moves the mode to Off on the next edge, with no power-off strobe. This also holds when a qualified wake arrives in the same cycle.
- R7: In Active, a qualified power-down request moves the mode to Standby and fires the power-off strobe.
- R8: In Active, losing a good battery (battery absent or below lockout) moves the mode to Off on the next edge and fires the power-off strobe. This takes priority over a power-down request in the same cycle.
- R9: The power-on strobe is high for exactly the one cycle in which the mode has just become Active. The power-off strobe is high for exactly the one cycle in which the mode has just left Active. The two strobes are never high together.
- R10: A wake source held high continuously produces a single wake event. Holding it through a power-down does not return the block to Active.
- R11: In Off without a good battery, wake sources are ignored and the mode stays Off.
- R12: The mode encoding is Off = 2'b00, Standby = 2'b01, Active = 2'b10. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 1 | Push-button wake flag |
| wall_i | input | 1 | Wall-adapter attach flag |
| usb_i | input | 1 | USB attach flag |
| pdn_req_i | input | 1 | Power-down request flag |
| batt_present_i | input | 1 | Battery present flag |
| batt_uvlo_ok_i | input | 1 | Battery above lockout threshold |
| batt_lowalm_ok_i | input | 1 | Battery above low-alarm threshold |
| mode_o | output | 2 | Current mode (Off 00, Standby 01, Active 10) |
| pwr_on_evt_o | output | 1 | One-cycle strobe on entry to Active |
| pwr_off_evt_o | output | 1 | One-cycle strobe on exit from Active |

## Verification
The filtered events and the unfiltered battery loss can reach the mode logic in the same cycle. Two such coincidences are tested:

- A power-down request held for `FILT_LEN` samples in Active.
- A wake held for `FILT_LEN` samples in Standby.

In each case the bench lowers the lockout flag at the negative edge just before the qualifying edge, so both conditions meet at one clock edge. The outcome must be Off: with the power-off strobe when leaving Active, and with no power-on strobe when leaving Standby. A behavioural model in the bench runs every cycle and flags any other collision that the directed sequence produces.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_STBY = 2'b01,
        MODE_ACT  = 2'b10
    } mode_t;

    // index of each filtered input in the filter bank
    localparam int SRC_BTN  = 0;
    localparam int SRC_WALL = 1;
    localparam int SRC_USB  = 2;
    localparam int SRC_PDN  = 3;
    localparam int NUM_SRC  = 4;

    typedef struct packed {
        logic batt_ok;
        logic lowalm_ok;
        logic wake;
        logic pdn;
    } mode_in_t;

    function automatic mode_t next_mode(mode_t cur, mode_in_t in);
        mode_t nxt;
        nxt = cur;
        if (!in.batt_ok) begin
            nxt = MODE_OFF;
        end else begin
            case (cur)
                MODE_OFF: begin
                    if (!in.lowalm_ok)  nxt = MODE_STBY;
                    else if (in.wake)   nxt = MODE_ACT;
                end
                MODE_STBY: begin
                    if (in.wake)        nxt = MODE_ACT;
                end
                MODE_ACT: begin
                    if (in.pdn)         nxt = MODE_STBY;
                end
                default:                nxt = MODE_OFF;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/stab_filter.sv
module stab_filter #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic qual_o
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] run_q;
    logic          qual_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            qual_q <= 1'b0;
        end else begin
            // one strobe when the run length reaches LEN
            qual_q <= raw_i && (run_q == CW'(LEN - 1));
            if (!raw_i)
                run_q <= '0;
            else if (run_q != CW'(LEN))
                run_q <= run_q + 1'b1;
        end
    end

    assign qual_o = qual_q;
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mode_in_t in_i,
    output mode_t    mode_o,
    output logic     on_evt_o,
    output logic     off_evt_o
);
    mode_t mode_q, mode_d;
    logic  on_q, off_q;

    always_comb mode_d = next_mode(mode_q, in_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
            on_q   <= 1'b0;
            off_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            on_q   <= (mode_d == MODE_ACT) && (mode_q != MODE_ACT);
            off_q  <= (mode_q == MODE_ACT) && (mode_d != MODE_ACT);
        end
    end

    assign mode_o    = mode_q;
    assign on_evt_o  = on_q;
    assign off_evt_o = off_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_i,
    input  logic       wall_i,
    input  logic       usb_i,
    input  logic       pdn_req_i,
    input  logic       batt_present_i,
    input  logic       batt_uvlo_ok_i,
    input  logic       batt_lowalm_ok_i,
    output logic [1:0] mode_o,
    output logic       pwr_on_evt_o,
    output logic       pwr_off_evt_o
);
    logic [NUM_SRC-1:0] raw_vec;
    logic [NUM_SRC-1:0] qual_vec;
    mode_in_t           fsm_in;
    mode_t              mode_w;

    always_comb begin
        raw_vec           = '0;
        raw_vec[SRC_BTN]  = btn_i;
        raw_vec[SRC_WALL] = wall_i;
        raw_vec[SRC_USB]  = usb_i;
        raw_vec[SRC_PDN]  = pdn_req_i;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_filt
        stab_filter #(.LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw_vec[g]),
            .qual_o (qual_vec[g])
        );
    end

    always_comb begin
        fsm_in.batt_ok   = batt_present_i && batt_uvlo_ok_i;
        fsm_in.lowalm_ok = batt_lowalm_ok_i;
        fsm_in.wake      = qual_vec[SRC_BTN] | qual_vec[SRC_WALL] | qual_vec[SRC_USB];
        fsm_in.pdn       = qual_vec[SRC_PDN];
    end

    mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_i      (fsm_in),
        .mode_o    (mode_w),
        .on_evt_o  (pwr_on_evt_o),
        .off_evt_o (pwr_off_evt_o)
    );

    assign mode_o = mode_w;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       batt_present_i,
    input logic       batt_uvlo_ok_i,
    input logic       batt_lowalm_ok_i,
    input logic [1:0] mode_o,
    input logic       pwr_on_evt_o,
    input logic       pwr_off_evt_o
);
    logic good;
    assign good = batt_present_i && batt_uvlo_ok_i;

    // R1
    a_r1_reset_off: assert property (@(posedge clk)
        rst |=> (mode_o == 2'b00 && !pwr_on_evt_o && !pwr_off_evt_o));

    // R12
    a_r12_legal_code: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'b11);

    // R9
    a_r9_on_entry: assert property (@(posedge clk) disable iff (rst)
        pwr_on_evt_o |-> (mode_o == 2'b10 && $past(mode_o) != 2'b10));

    // R9
    a_r9_off_exit: assert property (@(posedge clk) disable iff (rst)
        pwr_off_evt_o |-> (mode_o != 2'b10 && $past(mode_o) == 2'b10));

    // R9
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pwr_on_evt_o, pwr_off_evt_o}));

    // R3
    a_r3_to_standby: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b00 && good && !batt_lowalm_ok_i) |=> (mode_o == 2'b01 && !pwr_on_evt_o));

    // R11
    a_r11_stay_off: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b00 && !good) |=> mode_o == 2'b00);

    // R8
    a_r8_active_loss: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10 && !good) |=> (mode_o == 2'b00 && pwr_off_evt_o));

    // R6
    a_r6_standby_loss: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b01 && !good) |=> (mode_o == 2'b00 && !pwr_off_evt_o));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .batt_present_i   (batt_present_i),
    .batt_uvlo_ok_i   (batt_uvlo_ok_i),
    .batt_lowalm_ok_i (batt_lowalm_ok_i),
    .mode_o           (mode_o),
    .pwr_on_evt_o     (pwr_on_evt_o),
    .pwr_off_evt_o    (pwr_off_evt_o)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
    localparam int N = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn = 0, wall = 0, usb = 0, pdn = 0;
    logic pres = 0, uvlo = 0, lowalm = 0;
    logic [1:0] mode;
    logic on_evt, off_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.FILT_LEN(N)) uut (
        .clk              (clk),
        .rst              (rst),
        .btn_i            (btn),
        .wall_i           (wall),
        .usb_i            (usb),
        .pdn_req_i        (pdn),
        .batt_present_i   (pres),
        .batt_uvlo_ok_i   (uvlo),
        .batt_lowalm_ok_i (lowalm),
        .mode_o           (mode),
        .pwr_on_evt_o     (on_evt),
        .pwr_off_evt_o    (off_evt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model: 0=Off 1=Standby 2=Active
    int m_mode = 0;
    bit m_on = 0, m_off = 0;
    int run [4];
    bit hit [4];

    always @(posedge clk) begin
        bit raw [4];
        bit ok, wk;
        int nm;
        raw[0] = btn; raw[1] = wall; raw[2] = usb; raw[3] = pdn;
        if (rst) begin
            m_mode = 0; m_on = 0; m_off = 0;
            for (int i = 0; i < 4; i++) begin run[i] = 0; hit[i] = 0; end
        end else begin
            ok = pres && uvlo;
            wk = hit[0] || hit[1] || hit[2];
            nm = m_mode;
            if (!ok) nm = 0;
            else if (m_mode == 0) begin
                if (!lowalm) nm = 1;
                else if (wk) nm = 2;
            end else if (m_mode == 1) begin
                if (wk) nm = 2;
            end else if (hit[3]) nm = 1;
            m_on  = (nm == 2) && (m_mode != 2);
            m_off = (m_mode == 2) && (nm != 2);
            m_mode = nm;
            for (int i = 0; i < 4; i++) begin
                hit[i] = raw[i] && (run[i] == N - 1);
                run[i] = raw[i] ? ((run[i] < N) ? run[i] + 1 : N) : 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R12 mode vs model", int'(mode), m_mode);
            chk("R9 on strobe vs model", int'(on_evt), int'(m_on));
            chk("R9 off strobe vs model", int'(off_evt), int'(m_off));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        chk("R1 reset mode", int'(mode), 0);
        chk("R1 reset on strobe", int'(on_evt), 0);
        rst = 0;
        pres = 1; uvlo = 1; lowalm = 1;
        tick(3);
        chk("R4 no wake stays off", int'(mode), 0);

        // short button pulse
        btn = 1; tick(N - 1); btn = 0; tick(4);
        chk("R2 short pulse ignored", int'(mode), 0);

        // full qualification, direct to Active
        btn = 1; tick(N);
        chk("R2 not yet acted", int'(mode), 0);
        tick(1);
        chk("R4 direct to active", int'(mode), 2);
        chk("R9 on strobe", int'(on_evt), 1);
        tick(1);
        chk("R9 on strobe one cycle", int'(on_evt), 0);

        // power down while button still held
        pdn = 1; tick(N + 1);
        chk("R7 pdn to standby", int'(mode), 1);
        chk("R7 off strobe", int'(off_evt), 1);
        pdn = 0; tick(1);
        chk("R9 off strobe one cycle", int'(off_evt), 0);
        tick(5);
        chk("R10 held button no rewake", int'(mode), 1);
        btn = 0; tick(1);

        wall = 1; tick(N + 1);
        chk("R5 wall wake", int'(mode), 2);
        wall = 0; pdn = 1; tick(N + 1);
        chk("R7 pdn again", int'(mode), 1);
        pdn = 0; usb = 1; tick(N + 1);
        chk("R5 usb wake", int'(mode), 2);
        usb = 0; pdn = 1; tick(N + 1);
        pdn = 0;
        chk("R7 standby", int'(mode), 1);

        uvlo = 0; tick(1);
        chk("R6 standby loss to off", int'(mode), 0);
        chk("R6 no off strobe", int'(off_evt), 0);

        btn = 1; tick(N + 3);
        chk("R11 wake ignored low battery", int'(mode), 0);
        btn = 0; uvlo = 1; pres = 0; tick(1);
        wall = 1; tick(N + 3);
        chk("R11 wake ignored no battery", int'(mode), 0);
        wall = 0; pres = 1; lowalm = 0; tick(1);
        chk("R3 low alarm to standby", int'(mode), 1);
        chk("R3 no on strobe", int'(on_evt), 0);
        usb = 1; tick(N + 1);
        chk("R5 usb from standby", int'(mode), 2);
        usb = 0; lowalm = 1;

        uvlo = 0; tick(1);
        chk("R8 active loss to off", int'(mode), 0);
        chk("R8 off strobe", int'(off_evt), 1);
        uvlo = 1; tick(2);
        chk("R4 stays off without wake", int'(mode), 0);

        btn = 1; tick(N + 1);
        chk("R4 wake to active", int'(mode), 2);
        btn = 0;
        // coincidence: pdn qualifies on the same edge as battery loss
        pdn = 1; tick(N); uvlo = 0; tick(1);
        chk("R8 loss beats pdn", int'(mode), 0);
        chk("R8 off strobe coincide", int'(off_evt), 1);
        pdn = 0; uvlo = 1; lowalm = 0; tick(1);
        chk("R3 standby again", int'(mode), 1);
        lowalm = 1;
        // coincidence: wake qualifies on the same edge as battery loss
        wall = 1; tick(N); uvlo = 0; tick(1);
        chk("R6 loss beats wake", int'(mode), 0);
        chk("R6 no on strobe coincide", int'(on_evt), 0);
        wall = 0; uvlo = 1; tick(1);

        btn = 1; tick(N + 1);
        chk("R4 active before removal", int'(mode), 2);
        btn = 0; pres = 0; tick(1);
        chk("R8 removal to off", int'(mode), 0);
        chk("R8 removal off strobe", int'(off_evt), 1);
        tick(2);
        finish_run();
    end
endmodule